// File: doc/BRIEF.md
# Scheduled Power-Down Alarm Controller

This block is a second, independent calendar alarm whose purpose is to switch a system off. Software loads six BCD alarm fields, then sets a power-handover bit and an alarm-event enable bit. At each one-second calendar update, the block compares the current BCD time with the stored alarm. When they match, a status flag is latched. If both the handover bit and the event enable are set at that update, the external power-enable output is driven low.

A host that wants to shut down reads the time, adds at least two seconds, and writes the alarm fields. The margin is needed because all six fields must be in place before the next one-second update. The host then arms the block and waits for the external power chip to cut supply.

The power-enable output follows a three-state machine:

| State | Meaning |
|---|---|
| `PS_ON` | Handover disabled, output high. |
| `PS_ARMED` | Handover enabled, output high, waiting for a qualified match. |
| `PS_OFF` | Output low. |

The transitions are:

| Transition | Condition |
|---|---|
| ON→ARMED | The handover bit is set. |
| ARMED→ON | The handover bit is cleared. |
| ON→OFF and ARMED→OFF | A qualified match (handover set, event enabled, one-second update, all fields equal). |
| OFF→ON | The handover bit is clear and the status flag is clear. |

Top module: `pwrdn_alarm_top`

## Requirements
- R1: After reset, `pwr_en_o` is 1, `alarm_flag_o` is 0 and `irq_o` is 0. The handover bit, the event enable and all alarm fields reset to 0.
- R2: The alarm fields occupy offsets 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. In that order they hold seconds, minutes, hours, day, month and year, each taking `reg_wdata_i[7:0]`. In `now_time_i`, field i sits at bits [8i+7:8i] in the same order. A match needs all six fields equal. Writes to offsets the block does not decode change nothing.
- R3: The comparison is taken only in a cycle where `sec_tick_i` is 1. A matching time without a tick has no effect.
- R4: A tick with a match sets `alarm_flag_o` in the next cycle, whatever the enables are. Writing offset 0x44 with bit 7 set clears the flag. Bit 7 clear in that write leaves the flag unchanged. A new match in the same cycle as the clear wins over the clear.
- R5: Bit 4 of offset 0x48 is the event enable. `irq_o` is 1 exactly when the flag and the event enable are both 1.
- R6: Bit 16 of offset 0x98 is the handover bit. A tick with a match while the handover bit and the event enable are both set drives `pwr_en_o` low in the next cycle.
- R7: A tick with a match while only one of the two enables is set leaves `pwr_en_o` high.
- R8: Once `pwr_en_o` is low, it rises again only when the handover bit is 0 and the flag is 0. It rises one cycle after the later of those two registers clears. Clearing the handover bit while the flag is still set keeps the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse at each calendar one-second update |
| now_time_i | input | 48 | Current BCD time, six byte fields, seconds in the low byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| pwr_en_o | output | 1 | Power enable to the external supply, high means on |
| alarm_flag_o | output | 1 | Latched alarm status flag |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
Exact matches are mixed with times that differ from the alarm in one chosen field. This separates a full six-field compare from a partial one and catches a field mapped to the wrong byte. Ticks are applied both with and without a matching time, which tells update-gated evaluation apart from continuous comparison. Every combination of the handover bit and the event enable is driven while matches occur, which separates the qualified power-off from a plain flag. Random interleaving of status clears, handover clears and new matches exercises the ordering rules for releasing the output and the rule that a set beats a clear in the same cycle.

// File: rtl/pwrdn_alarm_pkg.sv
package pwrdn_alarm_pkg;
    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 6;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] ALM_BASE   = 8'h80;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h44;
    localparam logic [ADDR_W-1:0] IEN_ADDR   = 8'h48;
    localparam logic [ADDR_W-1:0] HAND_ADDR  = 8'h98;

    localparam int STAT_BIT = 7;
    localparam int IEN_BIT  = 4;
    localparam int HAND_BIT = 16;

    typedef enum logic [1:0] {
        PS_ON    = 2'd0,
        PS_ARMED = 2'd1,
        PS_OFF   = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/alarm_field.sv
module alarm_field #(
    parameter int                 FIELD_W = 8,
    parameter int                 ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  MY_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [FIELD_W-1:0] wbyte_i,
    input  logic [FIELD_W-1:0] now_i,
    output logic               eq_o
);
    logic [FIELD_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val_q <= '0;
        else if (wr_i && addr_i == MY_ADDR)
            val_q <= wbyte_i;
    end

    assign eq_o = (val_q == now_i);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import pwrdn_alarm_pkg::*;
#(
    parameter int FW   = FIELD_W,
    parameter int NF   = N_FIELDS,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [NF*FW-1:0] now_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             hand_o,
    output logic             ien_o,
    output logic             flag_o,
    output logic             hit_o
);
    localparam int STRIDE = 4;

    logic [NF-1:0] eq_vec;
    logic          hand_q, ien_q, flag_q;
    logic          clr_req;
    logic          unused_wdata;

    generate
        for (genvar i = 0; i < NF; i++) begin : g_field
            alarm_field #(
                .FIELD_W (FW),
                .ADDR_W  (AW),
                .MY_ADDR (AW'(ALM_BASE + AW'(STRIDE * i)))
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_i    (wr_i),
                .addr_i  (addr_i),
                .wbyte_i (wdata_i[FW-1:0]),
                .now_i   (now_i[i*FW +: FW]),
                .eq_o    (eq_vec[i])
            );
        end
    endgenerate

    assign hit_o        = tick_i && (&eq_vec);
    assign clr_req      = wr_i && addr_i == STAT_ADDR && wdata_i[STAT_BIT];
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hand_q <= 1'b0;
            ien_q  <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == HAND_ADDR) hand_q <= wdata_i[HAND_BIT];
            if (addr_i == IEN_ADDR)  ien_q  <= wdata_i[IEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit_o)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    assign hand_o = hand_q;
    assign ien_o  = ien_q;
    assign flag_o = flag_q;

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit_o) |=> !flag_o);

    // R3
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwrdn_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hand_i,
    input  logic fire_i,
    input  logic flag_i,
    output logic pwr_en_o
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_ON;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ON: begin
                if (hand_i && fire_i)  state_d = PS_OFF;
                else if (hand_i)       state_d = PS_ARMED;
            end
            PS_ARMED: begin
                if (hand_i && fire_i)  state_d = PS_OFF;
                else if (!hand_i)      state_d = PS_ON;
            end
            PS_OFF: begin
                if (!hand_i && !flag_i) state_d = PS_ON;
            end
            default: state_d = PS_ON;
        endcase
    end

    always_comb begin
        pwr_en_o = (state_q != PS_OFF);
    end

    // R7
    pin_fall_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_o) |-> $past(hand_i && fire_i));

    // R8
    pin_rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> $past(!hand_i && !flag_i));
endmodule

// File: rtl/pwrdn_alarm_top.sv
module pwrdn_alarm_top
    import pwrdn_alarm_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = N_FIELDS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick_i,
    input  logic [NF*FW-1:0] now_time_i,
    input  logic             reg_wr_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic             pwr_en_o,
    output logic             alarm_flag_o,
    output logic             irq_o
);
    logic hand, ien, flag, hit, fire;

    alarm_regs #(.FW(FW), .NF(NF), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (sec_tick_i),
        .now_i   (now_time_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .hand_o  (hand),
        .ien_o   (ien),
        .flag_o  (flag),
        .hit_o   (hit)
    );

    assign fire = hit && ien;

    pwr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hand_i   (hand),
        .fire_i   (fire),
        .flag_i   (flag),
        .pwr_en_o (pwr_en_o)
    );

    assign alarm_flag_o = flag;
    assign irq_o        = flag && ien;

    // R6
    qualified_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ien && hand) |=> !pwr_en_o);

    // R4
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag_o);
endmodule

// File: tb/pwrdn_alarm_top_tb_top.sv
`timescale 1ns/1ps
module pwrdn_alarm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] now_t = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        pwr_en, flag, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [7:0] m_alm [6];
    logic m_hand = 0, m_ien = 0, m_flag = 0, m_pin = 1;

    always #2.5 clk = ~clk;

    pwrdn_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(tick), .now_time_i(now_t),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .pwr_en_o(pwr_en), .alarm_flag_o(flag), .irq_o(irq)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [47:0] alarm_vec();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = m_alm[i];
        return v;
    endfunction

    function automatic logic model_match(logic [47:0] nw);
        return nw == alarm_vec();
    endfunction

    // one cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(bit w, logic [7:0] a, logic [31:0] d, bit tk, logic [47:0] nw);
        logic hit, fire, clr, pin_n, flag_n;
        wr = w; addr = a; wdata = d; tick = tk; now_t = nw;
        @(posedge clk);
        hit    = tk && model_match(nw);
        fire   = hit && m_ien && m_hand;
        clr    = w && a == 8'h44 && d[7];
        pin_n  = m_pin ? !fire : (!m_hand && !m_flag);
        flag_n = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
        if (w) begin
            for (int i = 0; i < 6; i++)
                if (a == 8'h80 + 8'(4*i)) m_alm[i] = d[7:0];
            if (a == 8'h98) m_hand = d[16];
            if (a == 8'h48) m_ien  = d[4];
        end
        m_pin = pin_n; m_flag = flag_n;
        @(negedge clk);
        chk("R6 R7 R8 pwr_en", pwr_en, m_pin);
        chk("R2 R3 R4 flag", flag, m_flag);
        chk("R5 irq", irq, m_flag && m_ien);
    endtask

    task automatic idle(logic [47:0] nw); step(0, 8'h00, 0, 0, nw); endtask

    task automatic load_alarm(logic [47:0] v);
        for (int i = 0; i < 6; i++) step(1, 8'h80 + 8'(4*i), {24'h0, v[i*8 +: 8]}, 0, 48'h0);
    endtask

    localparam logic [47:0] T_A = 48'h25_07_14_09_30_58;
    localparam logic [47:0] T_A_YR = 48'h26_07_14_09_30_58;   // year differs
    localparam logic [47:0] T_A_SEC = 48'h25_07_14_09_30_57;  // seconds differ

    initial begin
        for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
        void'($urandom(32'd4021));
        repeat (3) @(negedge clk);
        // R1 reset values visible while held and after release
        chk("R1 pwr_en reset", pwr_en, 1'b1);
        chk("R1 flag reset", flag, 1'b0);
        chk("R1 irq reset", irq, 1'b0);
        rst_n = 1'b1;
        idle(48'h1);

        // R2 field mapping and unmapped writes
        load_alarm(T_A);
        step(1, 8'h84 + 8'h01, 32'h0000_00FF, 0, 0); // odd offset ignored
        step(1, 8'h9C, 32'hFFFF_FFFF, 0, 0);          // undecoded offset ignored
        // R3 match without tick does nothing
        step(0, 0, 0, 0, T_A);
        // R2 one differing field: no flag
        step(0, 0, 0, 1, T_A_YR);
        step(0, 0, 0, 1, T_A_SEC);
        // R4 match with enables off sets flag, pin stays (R7)
        step(0, 0, 0, 1, T_A);
        chk("R4 flag set no enables", flag, 1'b1);
        chk("R7 pin high no enables", pwr_en, 1'b1);
        step(1, 8'h44, 32'h0000_007F, 0, 0);   // R4 bit7 clear: no effect
        chk("R4 flag kept", flag, 1'b1);
        step(1, 8'h44, 32'h0000_0080, 0, 0);   // R4 clear
        chk("R4 flag cleared", flag, 1'b0);
        // R5 and R7: event enable only
        step(1, 8'h48, 32'h0000_0010, 0, 0);
        step(0, 0, 0, 1, T_A);
        chk("R5 irq with enable", irq, 1'b1);
        chk("R7 pin high ien only", pwr_en, 1'b1);
        // R4 set wins over clear in the same cycle
        step(1, 8'h44, 32'h80, 1, T_A);
        chk("R4 set beats clear", flag, 1'b1);
        step(1, 8'h44, 32'h80, 0, 0);
        // R7 handover only
        step(1, 8'h48, 32'h0, 0, 0);
        step(1, 8'h98, 32'h0001_0000, 0, 0);
        step(0, 0, 0, 1, T_A);
        chk("R7 pin high handover only", pwr_en, 1'b1);
        step(1, 8'h44, 32'h80, 0, 0);
        // R6 both set: pin drops next cycle
        step(1, 8'h48, 32'h10, 0, 0);
        step(0, 0, 0, 1, T_A);
        chk("R6 pin low", pwr_en, 1'b0);
        // R8 clear handover with flag still set: stays low
        step(1, 8'h98, 32'h0, 0, 0);
        idle(0);
        chk("R8 pin held low by flag", pwr_en, 1'b0);
        step(1, 8'h44, 32'h80, 0, 0);
        idle(0);
        chk("R8 pin released", pwr_en, 1'b1);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 9);
            logic [7:0] a;
            logic [31:0] d = $urandom;
            logic [47:0] nw = alarm_vec();
            bit w = ($urandom_range(0, 2) == 0);
            unique case (sel)
                0, 1:    a = 8'h80 + 8'(4 * $urandom_range(0, 5));
                2, 3:    a = 8'h98;
                4, 5:    a = 8'h48;
                6, 7:    a = 8'h44;
                default: a = 8'($urandom_range(0, 255));
            endcase
            if (a >= 8'h80 && a <= 8'h94) d[7:0] = nw[8*((a - 8'h80) >> 2) +: 8] ^ 8'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1)
                nw[8 * $urandom_range(0, 5) +: 8] ^= 8'h01;
            step(w, a, d, ($urandom_range(0, 2) == 0), nw);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule